// File: doc/BRIEF.md
# Tick-Paced Hexadecimal Display Counter

This block runs on its own once reset is released. It shows a hexadecimal digit that climbs from 0 to F, one step per slow period, and then starts again at 0. The only inputs are the system clock and a synchronous reset. The block needs no other stimulus.

Two free-running prescalers divide the system clock into one-cycle enable strobes. No derived clocks are used. The first strobe paces the visible count. The second strobe rotates a one-hot digit-select ring, which scans a multiplexed display. With a 100 MHz clock, the default dividers give one count step per second and a 1 kHz scan rate.

Both divide ratios are parameters, so a test setup can shrink them to a few cycles. The count value drives a full hex-to-seven-segment decoder. Only the lowest digit position shows the count; the other positions are dark.

Top module: `hex_count_display`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `countValue` to 0 and `digitSel` to bit 0 only. It also clears both prescalers, so the first count step after release comes exactly COUNT_DIV edges later.
- R2: Number the edges from 1 starting with the first edge after reset release. After k edges, `countValue` equals floor(k / COUNT_DIV) mod 16. The value holds between steps and never advances by more than one at a time.
- R3: On the step after 15, `countValue` wraps to 0. The counting then continues at 1, 2 and so on.
- R4: Each prescaler fires for exactly one cycle in every DIV cycles, and these strobes are the only thing that moves the count and the digit ring.
- R5: While `digitSel[0]` is high, `segments` shows the active-high pattern for `countValue`, with bit 0 as segment a through bit 6 as segment g. The patterns for values 0 through F are, in hex: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R6: `digitSel` always has exactly one bit set. After k edges it is bit ((floor(k / SCAN_DIV)) mod NUM_DIGITS). Each scan strobe moves it up one position, and it wraps from the top bit back to bit 0.
- R7: While any digit other than bit 0 is selected, `segments` is all zeros, so that position is blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| segments | output | 7 | Segment drive, active high, bit 0 = a through bit 6 = g |
| digitSel | output | NUM_DIGITS | One-hot digit enable, active high |
| countValue | output | 4 | Current displayed count |

## Verification
A prescaler that is off by one moves every later count step by one cycle. That drift grows each slow period, so it shows on `countValue` at the first step after reset. A slow counter that skips, stalls or fails to wrap shows within one COUNT_DIV period of the error. A bad decoder entry shows as a wrong `segments` value on the first cycle that value is displayed. A ring that loses its one-hot state shows on `digitSel` at the next scan strobe, and blanking faults show on `segments` whenever a digit other than bit 0 is selected.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

  localparam int HEX_W = 4;
  localparam int SEG_W = 7;

  typedef struct packed {
    logic countTick;
    logic scanTick;
  } ctrlStrobes_t;

  // active-high segments, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] hexToSeg(input logic [HEX_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hcd_prescaler.sv
module hcd_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] divCnt;

  generate
    if (DIV > 1) begin : g_div
      assign tick = (divCnt == LAST);
      always_ff @(posedge clk) begin
        if (rst)       divCnt <= '0;
        else if (tick) divCnt <= '0;
        else           divCnt <= divCnt + 1'b1;
      end
    end else begin : g_pass
      assign tick = 1'b1;
      always_ff @(posedge clk) divCnt <= '0;
    end
  endgenerate

endmodule

// File: rtl/hcd_control.sv
module hcd_control
  import hcd_pkg::*;
#(
  parameter int COUNT_DIV = 100_000_000,
  parameter int SCAN_DIV  = 100_000
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes
);
  logic countTick;
  logic scanTick;

  hcd_prescaler #(.DIV(COUNT_DIV)) u_countDiv (
    .clk  (clk),
    .rst  (rst),
    .tick (countTick)
  );

  hcd_prescaler #(.DIV(SCAN_DIV)) u_scanDiv (
    .clk  (clk),
    .rst  (rst),
    .tick (scanTick)
  );

  always_comb begin
    strobes.countTick = countTick;
    strobes.scanTick  = scanTick;
  end

endmodule

// File: rtl/hcd_datapath.sv
module hcd_datapath
  import hcd_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  output logic [SEG_W-1:0]      segments,
  output logic [NUM_DIGITS-1:0] digitSel,
  output logic [HEX_W-1:0]      countValue
);
  logic [HEX_W-1:0]      slowCnt;
  logic [NUM_DIGITS-1:0] ringReg;
  logic [NUM_DIGITS-1:0] ringNext;

  always_ff @(posedge clk) begin
    if (rst)                    slowCnt <= '0;
    else if (strobes.countTick) slowCnt <= slowCnt + 1'b1;
  end

  generate
    if (NUM_DIGITS > 1) begin : g_ring
      assign ringNext = {ringReg[NUM_DIGITS-2:0], ringReg[NUM_DIGITS-1]};
    end else begin : g_single
      assign ringNext = ringReg;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                   ringReg <= NUM_DIGITS'(1);
    else if (strobes.scanTick) ringReg <= ringNext;
  end

  always_comb begin
    segments   = ringReg[0] ? hexToSeg(slowCnt) : '0;
    digitSel   = ringReg;
    countValue = slowCnt;
  end

endmodule

// File: rtl/hex_count_display.sv
module hex_count_display
  import hcd_pkg::*;
#(
  parameter int COUNT_DIV  = 100_000_000,
  parameter int SCAN_DIV   = 100_000,
  parameter int NUM_DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [6:0]            segments,
  output logic [NUM_DIGITS-1:0] digitSel,
  output logic [3:0]            countValue
);
  ctrlStrobes_t strobes;

  hcd_control #(.COUNT_DIV(COUNT_DIV), .SCAN_DIV(SCAN_DIV)) u_control (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  hcd_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .segments   (segments),
    .digitSel   (digitSel),
    .countValue (countValue)
  );

endmodule

// File: rtl/hcd_checker.sv
module hcd_checker
  import hcd_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input ctrlStrobes_t          strobes,
  input logic [6:0]            segments,
  input logic [NUM_DIGITS-1:0] digitSel,
  input logic [3:0]            countValue
);
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= !rst;

  // R2: count only ever moves by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$stable(countValue)) |-> (countValue == 4'($past(countValue) + 1)));

  // R4: count holds without its strobe
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !strobes.countTick) |=> $stable(countValue));

  // R3: wrap from 15 to 0
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (pastValid && strobes.countTick && countValue == 4'hF) |=> (countValue == 4'h0));

  // R6: one-hot ring
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> ($countones(digitSel) == 1));

  // R6: ring holds without scan strobe
  a_r6_hold_no_scan: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !strobes.scanTick) |=> $stable(digitSel));

  // R7: blank on other positions
  a_r7_blank: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !digitSel[0]) |-> (segments == 7'h00));

  // R5: lit digit is never dark
  a_r5_lit: assert property (@(posedge clk) disable iff (rst)
    (pastValid && digitSel[0]) |-> (segments != 7'h00));

endmodule

bind hex_count_display hcd_checker #(.NUM_DIGITS(NUM_DIGITS)) u_hcdChecker (
  .clk        (clk),
  .rst        (rst),
  .strobes    (strobes),
  .segments   (segments),
  .digitSel   (digitSel),
  .countValue (countValue)
);

// File: tb/hex_count_display_bench.sv
module hex_count_display_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CDIV = 5;
  localparam int SDIV = 3;
  localparam int ND   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [6:0]    segments;
  logic [ND-1:0] digitSel;
  logic [3:0]    countValue;

  int total = 0;
  int bad   = 0;

  hex_count_display #(.COUNT_DIV(CDIV), .SCAN_DIV(SDIV), .NUM_DIGITS(ND)) u_hex_count_display (
    .clk        (clk),
    .rst        (rst),
    .segments   (segments),
    .digitSel   (digitSel),
    .countValue (countValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // patterns as listed in R5
  function automatic logic [6:0] expSegOf(input int v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic checkOne(input string tag, input int act, input int exp, input int k);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // k = edges since reset release
  task automatic checkAt(input int k);
    int expCount = (k / CDIV) % 16;
    int expPos   = (k / SDIV) % ND;
    int expSel   = 1 << expPos;
    int expSeg   = (expPos == 0) ? int'(expSegOf(expCount)) : 0;
    string cTag  = (k == 0) ? "R1" : ((expCount == 0) ? "R3" : "R2");
    checkOne(cTag, int'(countValue), expCount, k);
    checkOne((k == 0) ? "R1" : "R6", int'(digitSel), expSel, k);
    checkOne((expPos == 0) ? "R5" : "R7", int'(segments), expSeg, k);
  endtask

  task automatic runEdges(input int n);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      checkAt(k);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkAt(0);              // R1 reset state
    runEdges(16 * CDIV * 2 + 7); // R2 R3 R4 R5 R6 R7, two full wraps
    // mid-run reset: R1
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkOne("R1", int'(countValue), 0, -1);
    checkOne("R1", int'(digitSel), 1, -1);
    rst = 1'b0;
    checkAt(0);
    runEdges(16 * CDIV + 3);  // R1 prescaler cleared: step timing restarts
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule